// File: doc/BRIEF.md
# Hardware Thread Selection Unit

This unit decides which of several hardware thread contexts feeds a scalar pipeline in the coming cycle. It supports two run-time policies. The interleaved policy grants a different context on every clock wherever one exists. The blocked policy keeps granting one context until that context stops being runnable, typically because a long-latency event such as a cache miss has been reported against it.

The unit tracks a blocked bit for each context. A stall pulse, tagged with a thread ID, sets the bit. A per-thread wake pulse clears it. A context is eligible when the external ready bit is high and the blocked bit, after this cycle's stall and wake pulses are applied, is low. Grants follow round-robin order, starting at the context after the last one granted. Ineligible contexts are skipped.

The policy input takes effect only on a switch boundary, so a policy change never interrupts a context that is being held. The selection is registered. `tid_o` and `valid_o` describe the grant made at the last clock edge.

Top module: `thr_sel_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `tid_o` equals NUM_THREADS-1. The first grant after reset is therefore thread 0 when thread 0 is eligible.
- R2: With `mode_i`=0 (interleaved), each clock with `issue_en_i` high grants the first eligible thread in round-robin order after the last grant. When two or more threads are eligible, `tid_o` changes on every such clock.
- R3: A thread whose `ready_i` bit is 0, or whose blocked bit is set, is never granted.
- R4: A `stall_i` pulse sets the blocked bit of thread `stall_tid_i`, and that thread is already excluded from the grant made at the same edge. The bit stays set until a wake pulse clears it.
- R5: `wake_i[k]`=1 clears the blocked bit of thread k, making it grantable at the same edge. If a stall pulse targets the same thread in the same cycle, the stall wins.
- R6: With `mode_i`=1 (blocked), the granted thread is granted again on every enabled clock for as long as it remains eligible.
- R7: In blocked policy, when the held thread becomes ineligible, the grant moves to the next eligible thread in round-robin order after it.
- R8: If no thread is eligible on an enabled clock, `valid_o` goes to 0 and `tid_o` keeps its previous value.
- R9: `mode_i` is sampled only on a switch boundary. A boundary is any interleaved-policy clock, a clock with no thread currently owned, or a clock on which the held thread is ineligible. A change of `mode_i` while a thread is held has no effect on `tid_o`.
- R10: With `issue_en_i`=0, the next `valid_o` is 0, and `tid_o`, ownership and policy are frozen. In blocked policy, re-enabling resumes the held thread if it is still eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Policy: 0 interleaved, 1 blocked |
| issue_en_i | input | 1 | Selection enable |
| ready_i | input | NUM_THREADS | Per-thread external ready bit |
| stall_i | input | 1 | Long-latency event pulse |
| stall_tid_i | input | TID_W | Thread that the stall pulse refers to |
| wake_i | input | NUM_THREADS | Per-thread pulse that clears the blocked bit |
| tid_o | output | TID_W | Granted thread ID, binary |
| valid_o | output | 1 | Grant is valid |

## Verification
The bench builds the unit with NUM_THREADS=4, so TID_W=2. With four contexts, the round-robin wrap from thread 3 back to thread 0, the single-eligible case and the fully blocked case are each reachable within a few cycles of directed stimulus. A reference model in the bench follows the requirements and predicts every grant during directed phases for each requirement. It then predicts every grant through a long random phase that mixes policy flips, stalls against the live thread, wakes and enable gaps.

// File: rtl/thr_sel_pkg.sv
package thr_sel_pkg;
  typedef enum logic {
    MODE_ILV = 1'b0,
    MODE_BLK = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/thr_block_tracker.sv
module thr_block_tracker #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   stall_i,
  input  logic [TID_W-1:0]       stall_tid_i,
  input  logic [NUM_THREADS-1:0] wake_i,
  output logic [NUM_THREADS-1:0] blk_q_o,
  output logic [NUM_THREADS-1:0] blk_nxt_o
);
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    logic hit;
    assign hit          = stall_i && (stall_tid_i == TID_W'(g));
    // stall dominates a coincident wake
    assign blk_nxt_o[g] = (blk_q_o[g] & ~wake_i[g]) | hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) blk_q_o[g] <= 1'b0;
      else         blk_q_o[g] <= blk_nxt_o[g];
    end

    assert_wake_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_i[g] && !(stall_i && stall_tid_i == TID_W'(g))) |=> !blk_q_o[g]);
  end

  assert_stall_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> blk_q_o[$past(stall_tid_i)]);
endmodule

// File: rtl/thr_rr_pick.sv
module thr_rr_pick #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0] elig_i,
  input  logic [TID_W-1:0]       last_i,
  output logic                   found_o,
  output logic [TID_W-1:0]       pick_o
);
  int idx;

  // search starts one past the last grant and wraps onto it last
  always_comb begin
    found_o = 1'b0;
    pick_o  = last_i;
    idx     = 0;
    for (int k = 1; k <= NUM_THREADS; k++) begin
      idx = (int'(last_i) + k) % NUM_THREADS;
      if (!found_o && elig_i[idx]) begin
        found_o = 1'b1;
        pick_o  = TID_W'(idx);
      end
    end
  end

  always_comb begin
    assert_pick_elig_R3: assert (!found_o || elig_i[pick_o]);
    assert_none_found_R8: assert (found_o || (elig_i == '0));
  end
endmodule

// File: rtl/thr_sel_unit.sv
module thr_sel_unit
  import thr_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic                   issue_en_i,
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic                   stall_i,
  input  logic [TID_W-1:0]       stall_tid_i,
  input  logic [NUM_THREADS-1:0] wake_i,
  output logic [TID_W-1:0]       tid_o,
  output logic                   valid_o
);
  localparam logic [TID_W-1:0] TID_RST = TID_W'(NUM_THREADS - 1);

  logic [NUM_THREADS-1:0] blk_q, blk_nxt, elig;
  logic [TID_W-1:0]       sel_q, pick;
  logic                   own_q, valid_q, found, boundary;
  sel_mode_e              mode_q;

  thr_block_tracker #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_blk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .stall_tid_i(stall_tid_i),
    .wake_i     (wake_i),
    .blk_q_o    (blk_q),
    .blk_nxt_o  (blk_nxt)
  );

  assign elig = ready_i & ~blk_nxt;

  thr_rr_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_pick (
    .elig_i (elig),
    .last_i (sel_q),
    .found_o(found),
    .pick_o (pick)
  );

  assign boundary = (mode_q == MODE_ILV) || !own_q || !elig[sel_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= TID_RST;
      own_q   <= 1'b0;
      valid_q <= 1'b0;
      mode_q  <= MODE_ILV;
    end else if (!issue_en_i) begin
      valid_q <= 1'b0;
    end else if (boundary) begin
      mode_q  <= sel_mode_e'(mode_i);
      own_q   <= found;
      valid_q <= found;
      if (found) sel_q <= pick;
    end else begin
      valid_q <= 1'b1;
    end
  end

  assign tid_o   = sel_q;
  assign valid_o = valid_q;

  assert_ilv_rotates_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ILV && issue_en_i && valid_o && $countones(elig) >= 2)
      |=> (valid_o && tid_o != $past(tid_o)));

  assert_blk_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BLK && issue_en_i && valid_o && ready_i[tid_o] && !blk_nxt[tid_o])
      |=> (valid_o && tid_o == $past(tid_o)));

  assert_mode_latched_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BLK && issue_en_i && valid_o && ready_i[tid_o] && !blk_nxt[tid_o])
      |=> (mode_q == MODE_BLK));

  assert_blk_moves_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BLK && issue_en_i && valid_o && !elig[tid_o] && elig != '0)
      |=> (valid_o && tid_o != $past(tid_o)));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_en_i && elig == '0) |=> (!valid_o && $stable(tid_o)));

  assert_gate_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_en_i |=> (!valid_o && $stable(tid_o)));

  assert_grant_ok_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_en_i && found) |=> !blk_q[tid_o]);
endmodule

// File: tb/sim_thr_sel_unit.sv
`timescale 1ns/1ps
module sim_thr_sel_unit;
  localparam int N  = 4;
  localparam int TW = 2;

  typedef struct {
    logic [TW-1:0] tid;
    logic          v;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0, en = 1'b0, stall = 1'b0;
  logic [N-1:0]  ready = '0, wake = '0;
  logic [TW-1:0] stid = '0;
  logic [TW-1:0] tid;
  logic          valid;

  int   n_run = 0, n_fail = 0;
  exp_t sb_q[$];

  // reference model state
  logic [TW-1:0] m_sel = TW'(N-1);
  logic          m_own = 1'b0, m_valid = 1'b0, m_mode = 1'b0;
  logic [N-1:0]  m_blk = '0;

  always #10 clk = ~clk;

  thr_sel_unit #(.NUM_THREADS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .issue_en_i(en),
    .ready_i(ready), .stall_i(stall), .stall_tid_i(stid), .wake_i(wake),
    .tid_o(tid), .valid_o(valid)
  );

  task automatic check(input string tag, input logic [TW-1:0] et, input logic ev);
    n_run++;
    if (valid !== ev || (ev && tid !== et) || (!ev && tid !== et)) begin
      n_fail++;
      $display("FAIL %s: tid=%0d valid=%0b expected tid=%0d valid=%0b", tag, tid, valid, et, ev);
    end
  endtask

  task automatic step(input logic [N-1:0] rdy, input logic stl, input logic [TW-1:0] st,
                      input logic [N-1:0] wk, input logic md, input logic ie, input string tag);
    logic [N-1:0] bn, el;
    logic bnd, fnd;
    int idx;
    exp_t e;
    @(negedge clk);
    ready = rdy; stall = stl; stid = st; wake = wk; mode = md; en = ie;
    bn = (m_blk & ~wk);
    if (stl) bn[st] = 1'b1;
    el = rdy & ~bn;
    if (!ie) m_valid = 1'b0;
    else begin
      bnd = (m_mode == 1'b0) || !m_own || !el[m_sel];
      if (bnd) begin
        m_mode = md;
        fnd = 1'b0;
        for (int k = 1; k <= N; k++) begin
          idx = (int'(m_sel) + k) % N;
          if (!fnd && el[idx]) begin fnd = 1'b1; m_sel = TW'(idx); end
        end
        m_own = fnd; m_valid = fnd;
      end else m_valid = 1'b1;
    end
    m_blk = bn;
    e.tid = m_sel; e.v = m_valid; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare 5 ns after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(e.tag, e.tid, e.v);
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog: tid=%0d valid=%0b expected completion", tid, valid);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", TW'(N-1), 1'b0);
    rst_n = 1'b1;
    // R2 interleaved rotation with all ready, wraps 3 -> 0
    for (int i = 0; i < 6; i++) step('1, 0, 0, '0, 0, 1, "R2");
    // R3 skip not-ready threads
    for (int i = 0; i < 4; i++) step(4'b1010, 0, 0, '0, 0, 1, "R3");
    // R4 stall the live thread: excluded at same edge and afterwards
    step('1, 1, m_sel, '0, 0, 1, "R4");
    for (int i = 0; i < 4; i++) step('1, 0, 0, '0, 0, 1, "R4");
    // R5 stall and wake on the same thread: stall wins
    step('1, 1, 2'd1, 4'b0010, 0, 1, "R5");
    step('1, 0, 0, 4'b0010, 0, 1, "R5");
    for (int i = 0; i < 4; i++) step('1, 0, 0, 4'b1111, 0, 1, "R5");
    // R6 blocked policy holds a ready thread
    for (int i = 0; i < 5; i++) step('1, 0, 0, '0, 1, 1, "R6");
    // R9 policy flips while held: ignored
    for (int i = 0; i < 3; i++) step('1, 0, 0, '0, 0, 1, "R9");
    step('1, 0, 0, '0, 1, 1, "R9");
    // R7 event on held thread moves grant to next eligible
    step('1, 1, m_sel, '0, 1, 1, "R7");
    step('1, 0, 0, '0, 1, 1, "R7");
    step('1, 1, m_sel, '0, 1, 1, "R7");
    step('1, 0, 0, '0, 1, 1, "R7");
    // R10 enable gap keeps the held thread
    for (int i = 0; i < 3; i++) step('1, 0, 0, '0, 1, 0, "R10");
    step('1, 0, 0, '0, 1, 1, "R10");
    // R8 nothing eligible
    step('0, 0, 0, '0, 1, 1, "R8");
    step('0, 0, 0, '0, 0, 1, "R8");
    step(4'b0011, 0, 0, 4'b1111, 0, 1, "R8");
    step('1, 1, 2'd0, '0, 0, 1, "R8");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic s;
      s = ($urandom % 4) == 0;
      step(N'($urandom), s, (($urandom % 2) == 0) ? m_sel : TW'($urandom), N'($urandom) & N'($urandom),
           logic'(($urandom % 8) != 0 ? m_mode : ~m_mode), logic'(($urandom % 10) != 0), "R3_R6_rand");
    end
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule